// File: doc/BRIEF.md
# Background Tile Fetch and Pixel Shifter

This block produces the background layer of a tile-based raster engine. While a render line is active it walks a fixed eight-cycle fetch rhythm: one cycle before each capture point it issues a read on a synchronous memory port. The reads fetch, in turn, the tile index, the attribute byte, and the low and high bit planes of the tile row. The captured bytes are merged into eight 4-bit pixels, each holding a 2-bit palette group and a 2-bit colour index. These pixels enter a 64-bit register that moves one pixel every fetch cycle.

On each cycle the output pixel is taken from the upper half of that register at an offset set by the fine horizontal scroll. Two tiles are fetched at the end of the previous line, so pixel 0 is ready when the visible part of the line starts. The scroll address `v`, the fine X scroll, the pattern-table half and the two display enables are inputs driven by the surrounding control logic.

Top module: `bg_fetch_pipe`

## Requirements
- R1: After reset the shift register is clear. `pix_o` is 0 for any fine X, and `mem_req_o` is low while rendering is disabled.
- R2: While active, at every dot `c` in 0..255 or 320..335 with `c mod 8 = 0`, a read is requested at address `0x2000 | (v & 0xFFF)`.
- R3: At such dots with `c mod 8 = 2`, an attribute read is requested at `0x23C0 | (v & 0xC00) | ((v>>4) & 0x38) | ((v>>2) & 0x07)`.
- R4: At `c mod 8 = 4` a low-plane read is requested at `pat_base*0x1000 + tile*16 + v[14:12]`. Here `tile` is the byte returned for the R2 read of the same group. At `c mod 8 = 6` the high-plane read goes to the same address plus 8.
- R5: Read data arrives one cycle after the request. At the dot that ends each group (`c mod 8 = 0`), eight pixels are built. Pixel j (j = 0 first) is `{attr2, hi[7-j], lo[7-j]}` and lands in the low 32 bits after the 4-bit left shift of that cycle.
- R6: `attr2` is the attribute byte shifted right by 4 when `v[6]` is set, then by 2 when `v[1]` is set. The low two bits of the result are used. `v` is taken at the attribute request.
- R7: At dot `d` in 1..256, `pix_o` equals pixel `(d-1+fine_x)` of the tile stream. The stream starts with the two tiles fetched on dots 321..336 of the previous line.
- R8: `pix_o` is 0 whenever `show_bg_i` is low.
- R9: `pix_o` is 0 on dots 1..8 when `show_left_i` is low.
- R10: While active, extra tile-index reads (address per R2) are issued at dots 336 and 338. The register does not move on dots 337..340, and no other reads occur outside the fetch windows.
- R11: When `render_en_i` or `line_active_i` is low, no reads are issued and the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_i | input | 9 | Current dot within the line (0..340) |
| line_active_i | input | 1 | Current line is a render or pre-render line |
| render_en_i | input | 1 | Rendering enabled |
| vaddr_i | input | 15 | Scroll address v (fine Y, table select, coarse Y, coarse X) |
| fine_x_i | input | 3 | Fine horizontal scroll |
| pat_base_i | input | 1 | Pattern-table half for background tiles |
| show_bg_i | input | 1 | Background display enable |
| show_left_i | input | 1 | Background display enable for the leftmost 8 pixels |
| mem_req_o | output | 1 | Read request, data expected on the next cycle |
| mem_addr_o | output | 14 | Read address |
| mem_data_i | input | 8 | Read data, valid the cycle after the request |
| pix_o | output | 4 | Background pixel {group, colour} |

## Verification
Requests and their addresses are combinational from the current dot and `v`. They are sampled in the same dot that is driven, one nanosecond after the falling edge. The memory model answers on the next rising edge, so each capture sees data requested exactly one dot earlier. The pixel for dot `d` reflects every shift up to the edge that ends dot `d-1`. The expected value is therefore stream pixel `d-1+fine_x`, read in dot `d`. The stream is rebuilt in the bench from the memory model and the scroll inputs. The no-move checks compare the pixel at dot 337 with dot 340, and a pixel held across a disabled stretch.

// File: rtl/bg_fetch_pkg.sv
package bg_fetch_pkg;
  typedef enum logic [1:0] {
    FK_NT   = 2'd0,
    FK_ATTR = 2'd1,
    FK_LO   = 2'd2,
    FK_HI   = 2'd3
  } fetch_kind_e;
endpackage

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq
  import bg_fetch_pkg::*;
#(
  parameter int DOT_W     = 9,
  parameter int VIS_LAST  = 256,
  parameter int PRE_FIRST = 321,
  parameter int PRE_LAST  = 336,
  parameter int DUMMY_CNT = 2
) (
  input  logic [DOT_W-1:0] dot_i,
  input  logic             go_i,
  output logic             req_o,
  output fetch_kind_e      req_kind_o,
  output logic             cap_o,
  output fetch_kind_e      cap_kind_o,
  output logic             shift_o,
  output logic             pack_o
);
  localparam logic [DOT_W-1:0] VIS_FIRST_D = DOT_W'(1);
  localparam logic [DOT_W-1:0] VIS_LAST_D  = DOT_W'(VIS_LAST);
  localparam logic [DOT_W-1:0] PRE_FIRST_D = DOT_W'(PRE_FIRST);
  localparam logic [DOT_W-1:0] PRE_LAST_D  = DOT_W'(PRE_LAST);

  function automatic logic in_win(input logic [DOT_W-1:0] d);
    return ((d >= VIS_FIRST_D) && (d <= VIS_LAST_D)) ||
           ((d >= PRE_FIRST_D) && (d <= PRE_LAST_D));
  endfunction

  logic [DOT_W-1:0]     nxt;
  logic [DUMMY_CNT-1:0] dmy_hit;
  logic                 req_fetch;

  assign nxt = dot_i + DOT_W'(1);

  // trailing tile-index reads with discarded data
  for (genvar i = 0; i < DUMMY_CNT; i++) begin : g_dmy
    assign dmy_hit[i] = (dot_i == DOT_W'(PRE_LAST + 2 * i));
  end

  always_comb begin
    shift_o    = go_i && in_win(dot_i);
    pack_o     = shift_o && (dot_i[2:0] == 3'd0);
    cap_o      = shift_o && dot_i[0];
    cap_kind_o = fetch_kind_e'(dot_i[2:1]);
    // request one dot ahead of the odd capture dot
    req_fetch  = go_i && in_win(nxt) && nxt[0];
    req_o      = req_fetch || (go_i && (|dmy_hit));
    req_kind_o = req_fetch ? fetch_kind_e'(nxt[2:1]) : FK_NT;
  end
endmodule

// File: rtl/bg_addr_gen.sv
module bg_addr_gen
  import bg_fetch_pkg::*;
#(
  parameter int V_W    = 15,
  parameter int ADDR_W = 14
) (
  input  fetch_kind_e       kind_i,
  input  logic [V_W-1:0]    vaddr_i,
  input  logic              pat_base_i,
  input  logic [7:0]        tile_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [2:0] fine_y;
  assign fine_y = vaddr_i[14:12];

  always_comb begin
    unique case (kind_i)
      FK_NT:   addr_o = {2'b10, vaddr_i[11:0]};
      FK_ATTR: addr_o = {2'b10, vaddr_i[11:10], 4'b1111, vaddr_i[9:7], vaddr_i[4:2]};
      FK_LO:   addr_o = {1'b0, pat_base_i, tile_i, 1'b0, fine_y};
      default: addr_o = {1'b0, pat_base_i, tile_i, 1'b1, fine_y};
    endcase
  end
endmodule

// File: rtl/bg_tile_pack.sv
module bg_tile_pack
  import bg_fetch_pkg::*;
#(
  parameter int TILE_PIX = 8,
  parameter int PIX_W    = 4,
  localparam int WORD_W  = TILE_PIX * PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  fetch_kind_e       cap_kind_i,
  input  logic [7:0]        data_i,
  input  logic              attr_req_i,
  input  logic              coarse_y1_i,
  input  logic              coarse_x1_i,
  output logic [7:0]        tile_o,
  output logic [WORD_W-1:0] word_o
);
  logic [7:0]          tile_q, lo_q, hi_q;
  logic [1:0]          attr_q, qsel_q, attr_sel;
  logic [TILE_PIX-1:0] lo_bits, hi_bits;

  always_comb begin
    unique case (qsel_q)
      2'b00:   attr_sel = data_i[1:0];
      2'b01:   attr_sel = data_i[3:2];
      2'b10:   attr_sel = data_i[5:4];
      default: attr_sel = data_i[7:6];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tile_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      attr_q <= '0;
      qsel_q <= '0;
    end else begin
      // quadrant chosen with v as it stood at the attribute request
      if (attr_req_i) qsel_q <= {coarse_y1_i, coarse_x1_i};
      if (cap_i) begin
        unique case (cap_kind_i)
          FK_NT:   tile_q <= data_i;
          FK_ATTR: attr_q <= attr_sel;
          FK_LO:   lo_q   <= data_i;
          default: hi_q   <= data_i;
        endcase
      end
    end
  end

  assign lo_bits = lo_q[TILE_PIX-1:0];
  assign hi_bits = hi_q[TILE_PIX-1:0];

  for (genvar j = 0; j < TILE_PIX; j++) begin : g_nib
    assign word_o[(TILE_PIX-1-j)*PIX_W +: PIX_W] =
      {attr_q, hi_bits[TILE_PIX-1-j], lo_bits[TILE_PIX-1-j]};
  end

  assign tile_o = tile_q;
endmodule

// File: rtl/bg_shift_out.sv
module bg_shift_out #(
  parameter int TILE_PIX  = 8,
  parameter int PIX_W     = 4,
  parameter int DOT_W     = 9,
  parameter int CLIP_LAST = 8,
  localparam int WORD_W   = TILE_PIX * PIX_W,
  localparam int TW       = 2 * WORD_W,
  localparam int FX_W     = $clog2(TILE_PIX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              pack_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [FX_W-1:0]   fine_x_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              show_bg_i,
  input  logic              show_left_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic [TW-1:0]     tile_o
);
  logic [TW-1:0]     tile_q;
  logic [WORD_W-1:0] upper;
  logic [FX_W-1:0]   nib_idx;
  logic [PIX_W-1:0]  raw_pix;
  logic              in_clip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tile_q <= '0;
    else if (shift_i)
      tile_q <= (tile_q << PIX_W) | (pack_i ? {{WORD_W{1'b0}}, word_i} : {TW{1'b0}});
  end

  assign upper   = tile_q[TW-1:WORD_W];
  assign nib_idx = FX_W'(TILE_PIX - 1) - fine_x_i;
  assign raw_pix = upper[nib_idx*PIX_W +: PIX_W];
  assign in_clip = (dot_i >= DOT_W'(1)) && (dot_i <= DOT_W'(CLIP_LAST));

  always_comb begin
    if (!show_bg_i || (in_clip && !show_left_i)) pix_o = '0;
    else pix_o = raw_pix;
  end

  assign tile_o = tile_q;
endmodule

// File: rtl/bg_fetch_pipe.sv
module bg_fetch_pipe
  import bg_fetch_pkg::*;
#(
  parameter int DOT_W     = 9,
  parameter int V_W       = 15,
  parameter int ADDR_W    = 14,
  parameter int TILE_PIX  = 8,
  parameter int PIX_W     = 4,
  parameter int VIS_LAST  = 256,
  parameter int PRE_FIRST = 321,
  parameter int PRE_LAST  = 336,
  parameter int DUMMY_CNT = 2,
  parameter int CLIP_LAST = 8,
  localparam int FX_W     = $clog2(TILE_PIX),
  localparam int WORD_W   = TILE_PIX * PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              line_active_i,
  input  logic              render_en_i,
  input  logic [V_W-1:0]    vaddr_i,
  input  logic [FX_W-1:0]   fine_x_i,
  input  logic              pat_base_i,
  input  logic              show_bg_i,
  input  logic              show_left_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic [PIX_W-1:0]  pix_o
);
  fetch_kind_e         req_kind, cap_kind;
  logic                go, cap, shift, pack;
  logic [7:0]          tile_idx;
  logic [WORD_W-1:0]   word;
  logic [2*WORD_W-1:0] tile_w;

  assign go = render_en_i && line_active_i;

  bg_fetch_seq #(
    .DOT_W(DOT_W), .VIS_LAST(VIS_LAST), .PRE_FIRST(PRE_FIRST),
    .PRE_LAST(PRE_LAST), .DUMMY_CNT(DUMMY_CNT)
  ) u_seq (
    .dot_i(dot_i), .go_i(go), .req_o(mem_req_o), .req_kind_o(req_kind),
    .cap_o(cap), .cap_kind_o(cap_kind), .shift_o(shift), .pack_o(pack)
  );

  bg_addr_gen #(.V_W(V_W), .ADDR_W(ADDR_W)) u_addr (
    .kind_i(req_kind), .vaddr_i(vaddr_i), .pat_base_i(pat_base_i),
    .tile_i(tile_idx), .addr_o(mem_addr_o)
  );

  bg_tile_pack #(.TILE_PIX(TILE_PIX), .PIX_W(PIX_W)) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .cap_kind_i(cap_kind),
    .data_i(mem_data_i), .attr_req_i(mem_req_o && (req_kind == FK_ATTR)),
    .coarse_y1_i(vaddr_i[6]), .coarse_x1_i(vaddr_i[1]),
    .tile_o(tile_idx), .word_o(word)
  );

  bg_shift_out #(
    .TILE_PIX(TILE_PIX), .PIX_W(PIX_W), .DOT_W(DOT_W), .CLIP_LAST(CLIP_LAST)
  ) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(shift), .pack_i(pack),
    .word_i(word), .fine_x_i(fine_x_i), .dot_i(dot_i),
    .show_bg_i(show_bg_i), .show_left_i(show_left_i),
    .pix_o(pix_o), .tile_o(tile_w)
  );
endmodule

// File: rtl/bg_fetch_pipe_chk.sv
module bg_fetch_pipe_chk #(
  parameter int DOT_W  = 9,
  parameter int V_W    = 15,
  parameter int ADDR_W = 14,
  parameter int PIX_W  = 4,
  parameter int TW     = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DOT_W-1:0]  dot_i,
  input logic              line_active_i,
  input logic              render_en_i,
  input logic [V_W-1:0]    vaddr_i,
  input logic              show_bg_i,
  input logic              show_left_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [PIX_W-1:0]  pix_o,
  input logic [TW-1:0]     tile_i
);
  logic active;
  assign active = render_en_i && line_active_i;

  assert_idle_no_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !mem_req_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> $stable(tile_i));

  assert_tail_no_shift_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_i >= DOT_W'(337) && dot_i <= DOT_W'(340)) |=> $stable(tile_i));

  assert_dummy_nt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && (dot_i == DOT_W'(336) || dot_i == DOT_W'(338)))
      |-> (mem_req_o && mem_addr_o[13:12] == 2'b10));

  assert_nt_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && dot_i[2:0] == 3'd0) |-> (mem_addr_o == {2'b10, vaddr_i[11:0]}));

  assert_hi_plane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && dot_i[2:0] == 3'd4 && dot_i < DOT_W'(336))
      |-> ##2 (mem_req_o && mem_addr_o == ($past(mem_addr_o, 2) | ADDR_W'(8))));

  assert_left_clip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!show_left_i && dot_i >= DOT_W'(1) && dot_i <= DOT_W'(8)) |-> (pix_o == '0));

  assert_bg_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !show_bg_i |-> (pix_o == '0));
endmodule

bind bg_fetch_pipe bg_fetch_pipe_chk #(
  .DOT_W(DOT_W), .V_W(V_W), .ADDR_W(ADDR_W), .PIX_W(PIX_W), .TW(2 * WORD_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dot_i(dot_i), .line_active_i(line_active_i),
  .render_en_i(render_en_i), .vaddr_i(vaddr_i), .show_bg_i(show_bg_i),
  .show_left_i(show_left_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .pix_o(pix_o), .tile_i(tile_w)
);

// File: tb/bg_fetch_pipe_test.sv
`timescale 1ns/1ps
module bg_fetch_pipe_test;
  localparam int WD_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  dot = '0;
  logic        line_act = 1'b0;
  logic        ren = 1'b0;
  logic [14:0] va = '0;
  logic [2:0]  fx = '0;
  logic        pbase = 1'b0;
  logic        sbg = 1'b0;
  logic        sleft = 1'b0;
  logic        mreq;
  logic [13:0] maddr;
  logic [7:0]  mrd;
  logic [3:0]  pix;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bg_fetch_pipe uut (
    .clk_i(clk), .rst_ni(rst_n), .dot_i(dot), .line_active_i(line_act),
    .render_en_i(ren), .vaddr_i(va), .fine_x_i(fx), .pat_base_i(pbase),
    .show_bg_i(sbg), .show_left_i(sleft), .mem_req_o(mreq),
    .mem_addr_o(maddr), .mem_data_i(mrd), .pix_o(pix)
  );

  function automatic int mem_f(int a);
    int m;
    m = a & 16'h3FFF;
    return (m * 197 + (m >> 6) + (m >> 11) * 53) & 255;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mrd <= '0;
    else if (mreq) mrd <= 8'(mem_f(int'(maddr)));

  function automatic int group_of(int c);
    if (c >= 320 && c < 336) return (c - 320) / 8;
    if (c >= 336) return 2;
    return 2 + c / 8;
  endfunction

  function automatic int v_of(int g, int cx0, int cy, int fy, int nts);
    return (fy << 12) | (nts << 10) | (cy << 5) | ((cx0 + g) & 31);
  endfunction

  function automatic int attr_addr(int v);
    return 'h23C0 | (v & 'h0C00) | ((v >> 4) & 'h38) | ((v >> 2) & 'h07);
  endfunction

  function automatic int pat_addr(int v, int base);
    return base * 4096 + mem_f('h2000 | (v & 'hFFF)) * 16 + ((v >> 12) & 7);
  endfunction

  function automatic int exp_nib(int s, int cx0, int cy, int fy, int nts, int base);
    int v, q, lo, hi, j;
    v  = v_of(s / 8, cx0, cy, fy, nts);
    j  = s % 8;
    q  = mem_f(attr_addr(v));
    if ((cy & 2) != 0) q = q >> 4;
    if ((((cx0 + s / 8) & 31) & 2) != 0) q = q >> 2;
    q  = q & 3;
    lo = mem_f(pat_addr(v, base));
    hi = mem_f(pat_addr(v, base) + 8);
    return (q << 2) | (((hi >> (7 - j)) & 1) << 1) | ((lo >> (7 - j)) & 1);
  endfunction

  task automatic chk(string req, int act, int expv, int c);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s dot=%0d act=%0h exp=%0h", req, c, act, expv);
    end
  endtask

  task automatic drive(int c, int v);
    @(negedge clk);
    dot = 9'(c);
    va  = 15'(v);
    #1;
  endtask

  // one full line: prefetch tail, then visible and idle dots
  task automatic run_line(int fxv, bit bg, bit lft, int cx0, int cy, int fy,
                          int nts, int base, string tag);
    int p337;
    p337 = 0;
    ren = 1'b1; line_act = 1'b1; fx = 3'(fxv); sbg = bg; sleft = lft;
    pbase = base[0];
    for (int k = 0; k < 341; k++) begin
      int c, ph, v, ea;
      bit fetch, dmy;
      c = (k < 21) ? 320 + k : k - 21;
      v = v_of(group_of(c), cx0, cy, fy, nts);
      drive(c, v);
      ph = c % 8;
      fetch = ((c <= 255) || (c >= 320 && c <= 335)) && (ph % 2 == 0);
      dmy = (c == 336) || (c == 338);
      chk(fetch ? "R2 req" : "R10 req", int'(mreq), int'(fetch || dmy), c);
      if (dmy) chk("R10 dummy addr", int'(maddr), 'h2000 | (v & 'hFFF), c);
      else if (fetch) begin
        case (ph)
          0: begin ea = 'h2000 | (v & 'hFFF); chk("R2 addr", int'(maddr), ea, c); end
          2: begin ea = attr_addr(v); chk("R3 addr", int'(maddr), ea, c); end
          4: begin ea = pat_addr(v, base); chk("R4 lo addr", int'(maddr), ea, c); end
          default: begin ea = pat_addr(v, base) + 8; chk("R4 hi addr", int'(maddr), ea, c); end
        endcase
      end
      if (c == 337) p337 = int'(pix);
      if (c == 340 && bg) chk("R10 no shift", int'(pix), p337, c);
      if (c >= 1 && c <= 256) begin
        if (!bg) chk("R8", int'(pix), 0, c);
        else if (c <= 8 && !lft) chk("R9", int'(pix), 0, c);
        else chk(tag, int'(pix), exp_nib(c - 1 + fxv, cx0, cy, fy, nts, base), c);
      end
    end
  endtask

  // disabled stretch: no reads, register must not move
  task automatic hold_check(bit r, bit l);
    int p0;
    ren = r; line_act = l; sbg = 1'b1; sleft = 1'b1; fx = 3'd2;
    for (int k = 0; k < 62; k++) begin
      int c;
      c = (k < 21) ? 320 + k : k - 21;
      drive(c, v_of(group_of(c), 5, 9, 1, 2));
      if (k == 0) p0 = int'(pix);
      chk("R11 req", int'(mreq), 0, c);
      chk("R11 hold", int'(pix), p0, c);
    end
  endtask

  task automatic reset_test();
    rst_n = 1'b0; ren = 1'b0; sbg = 1'b1; fx = 3'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      drive(100 + k, 'h1234);
      chk("R1 pix", int'(pix), 0, 100 + k);
      chk("R1 req", int'(mreq), 0, 100 + k);
    end
  endtask

  initial begin
    #(WD_CYC * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    reset_test();
    run_line(0, 1'b1, 1'b1, 0, 0, 3, 0, 0, "R5 R7");
    run_line(5, 1'b1, 1'b0, 3, 2, 6, 3, 1, "R6 R7");
    run_line(1, 1'b0, 1'b1, 9, 7, 2, 1, 0, "R8");
    hold_check(1'b0, 1'b1);
    hold_check(1'b1, 1'b0);
    run_line(7, 1'b1, 1'b1, 30, 18, 5, 2, 1, "R6 R7");
    run_line(2, 1'b1, 1'b0, 14, 27, 0, 1, 0, "R5 R7");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule